// File: doc/BRIEF.md
# Codec Frame-Synced Serial Port

This block is the digital serial port of a data converter, running as the master of a four-wire link: shift clock, frame sync, serial data out and serial data in. It divides the system clock by four to make the shift clock, and it opens 16-bit transfer windows by pulling frame sync low for one shift clock. A primary window opens every 64 shift clocks. In that window the converter's current ADC sample shifts out while the next DAC sample shifts in, both at the same time.

A secondary window can be placed 32 shift clocks after a primary one. It carries a control word from the host. The word either writes one byte of a small register file or reads one byte back on the same window's output. The port adds a secondary window only when a request is pending. A request comes from a hardware pin or from a software bit in register 0. An active-low run input freezes the port and clears its counters, but keeps the register contents. A synchronous reset brings the whole port back to its default state.

Top module: `codec_sport`

## Requirements
- R1: `sclk` has a period of 4 `clk` cycles: high for 2 and low for 2. `dout` changes only as `sclk` rises, and `din` is captured as `sclk` falls.
- R2: `fs_n` falls together with a rising edge of `sclk` and stays low for exactly one shift clock. The 16 data bits follow on the next 16 shift clocks, most significant bit first.
- R3: Primary windows start every 64 shift clocks. Their `dout` bits are the value of `adc_word` captured on the clock edge where `fs_n` falls. Later changes to `adc_word` do not affect a window already in progress.
- R4: After the 16th bit of every primary window, `dac_word` holds the 16 bits received on `din`, and `dac_stb` is high for one `clk` cycle.
- R5: A secondary window starts 32 shift clocks after a primary start, and only when a request is pending. With no request, no secondary window appears.
- R6: `req_pin` high on any `clk` edge leaves a request pending until the next secondary window. If the pin is held high, a secondary window appears in every period.
- R7: The secondary control word is laid out as follows. Bit 15 is the direction (1 = read, 0 = write), bits 14:8 are the register address, and bits 7:0 are the data. A write to an address below NREG (8) stores the data and pulses `wr_stb` for one `clk` cycle after the 16th bit.
- R8: In a read window, `dout` bits 15:8 are 0 and bits 7:0 are the addressed register. In a write window, all 16 `dout` bits are 0.
- R9: An address of NREG or above cannot be written: nothing is stored and `wr_stb` stays low. A read from such an address returns 0.
- R10: Writing 1 to bit 0 of register 0 requests a secondary window. That bit clears itself when the requested window starts, so a read of register 0 in that window returns bit 0 = 0.
- R11: While `run_en` is low, `sclk` is 0, `fs_n` is 1, a partly sent window is dropped without a strobe, and the registers keep their values. On the first `clk` edge with `run_en` high, `fs_n` falls and a primary window begins.
- R12: `rst` is synchronous. It drives `sclk`, `dout`, `dac_stb` and `wr_stb` to 0 and `fs_n` to 1, and clears every register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Low powers the port down, high runs it |
| adc_word | input | 16 | ADC sample holding register |
| req_pin | input | 1 | Hardware request for a secondary window |
| din | input | 1 | Serial data from the host |
| sclk | output | 1 | Shift clock |
| fs_n | output | 1 | Frame sync, active low |
| dout | output | 1 | Serial data to the host |
| dac_word | output | 16 | Last DAC sample received |
| dac_stb | output | 1 | One-cycle pulse per DAC word received |
| wr_stb | output | 1 | One-cycle pulse per register write |

## Verification
The primary exchange is driven with complementary all-ones and all-zeros words, an asymmetric pattern and edge-bit patterns, so that bit order, bit reversal and stuck lanes each show up as distinct mismatches. The ADC input is changed just after a frame-sync edge, which separates a latch at that edge from a live feed. Secondary traffic is tested four ways: a single pin pulse, a held pin, the self-clearing software bit, and no request at all. Together these separate correct request handling from missing, repeated or spurious control windows. Reads back from in-range and out-of-range addresses, taken after power-down and after reset, tell register retention apart from register clearing.

// File: rtl/sport_pkg.sv
package sport_pkg;

  // Kind of data bit currently on the link.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_PRIM = 2'd1,
    SLOT_SEC  = 2'd2
  } slot_e;

endpackage

// File: rtl/sport_timebase.sv
module sport_timebase
  import sport_pkg::*;
#(
  parameter int DIV     = 4,
  parameter int WORD_W  = 16,
  parameter int PERIOD  = 64,
  parameter int SEC_OFS = 32,
  parameter int BN_W    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic            req_pin,
  input  logic            req_sw,
  output logic            sclk,
  output logic            fs_n,
  output logic            launch,
  output logic            sample,
  output logic            prim_start,
  output logic            sec_start,
  output slot_e           slot,
  output logic [BN_W-1:0] bitn
);

  localparam int PH_W = $clog2(DIV);
  localparam int SC_W = $clog2(PERIOD);

  logic [PH_W-1:0] ph;
  logic [SC_W-1:0] sc;
  logic            sec_act;
  logic            pin_pend;
  logic            sec_pend;
  logic            prim_bits;
  logic            sec_bits;

  assign sec_pend   = pin_pend | req_sw;
  assign launch     = run_en && (ph == '0);
  assign sample     = run_en && (int'(ph) == DIV / 2);
  assign prim_start = launch && (sc == '0);
  assign sec_start  = launch && (int'(sc) == SEC_OFS) && sec_pend;

  assign prim_bits = (int'(sc) >= 1) && (int'(sc) <= WORD_W);
  assign sec_bits  = sec_act && (int'(sc) > SEC_OFS) && (int'(sc) <= SEC_OFS + WORD_W);

  always_comb begin
    slot = SLOT_IDLE;
    bitn = '0;
    if (prim_bits) begin
      slot = SLOT_PRIM;
      bitn = BN_W'(int'(sc));
    end else if (sec_bits) begin
      slot = SLOT_SEC;
      bitn = BN_W'(int'(sc) - SEC_OFS);
    end
  end

  // Hardware request latch; a new request on the clearing edge wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_pend <= 1'b0;
    end else if (req_pin) begin
      pin_pend <= 1'b1;
    end else if (sec_start) begin
      pin_pend <= 1'b0;
    end
  end

  // Phase and shift-clock counters, shift clock and frame sync.
  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      ph      <= '0;
      sc      <= '0;
      sclk    <= 1'b0;
      fs_n    <= 1'b1;
      sec_act <= 1'b0;
    end else begin
      ph <= (int'(ph) == DIV - 1) ? '0 : ph + PH_W'(1);
      if (int'(ph) == DIV - 1) begin
        sc <= (int'(sc) == PERIOD - 1) ? '0 : sc + SC_W'(1);
      end
      if (launch) begin
        sclk <= 1'b1;
        fs_n <= !(prim_start || sec_start);
        if (int'(sc) == SEC_OFS) begin
          sec_act <= sec_pend;
        end
      end
      if (sample) begin
        sclk <= 1'b0;
      end
    end
  end

  // R2: frame sync only falls on a rising shift-clock edge
  a_r2_fs_on_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(fs_n) |-> $rose(sclk));

  // R11: powered down means an idle link on the next cycle
  a_r11_pd_idle: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!sclk && fs_n));

  // R1: shift clock stays high for a second cycle after rising
  a_r1_sclk_high: assert property (@(posedge clk) disable iff (rst || !run_en)
    $rose(sclk) |=> sclk);

endmodule

// File: rtl/sport_shifter.sv
module sport_shifter
  import sport_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DAT_W  = 8,
  parameter int ADDR_W = 7,
  parameter int BN_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              launch,
  input  logic              sample,
  input  logic              prim_start,
  input  slot_e             slot,
  input  logic [BN_W-1:0]   bitn,
  input  logic [WORD_W-1:0] adc_word,
  input  logic              din,
  input  logic [DAT_W-1:0]  rd_data,
  output logic              dout,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_stb,
  output logic              hdr_vld,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              sec_vld,
  output logic [WORD_W-1:0] sec_word
);

  localparam int HDR_W = WORD_W - DAT_W;
  localparam int IX_W  = $clog2(WORD_W);
  localparam int RX_W  = $clog2(DAT_W);

  logic [WORD_W-1:0] adc_hold;
  logic [WORD_W-2:0] rx;
  logic              rd_sel;
  logic [IX_W-1:0]   tx_ix;
  logic [RX_W-1:0]   rd_ix;
  logic [WORD_W-1:0] full;

  assign tx_ix = IX_W'(WORD_W - int'(bitn));
  assign rd_ix = RX_W'(WORD_W - int'(bitn));
  assign full  = {rx, din};

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_hold <= '0;
      dac_word <= '0;
      sec_word <= '0;
      hdr_addr <= '0;
    end else if (run_en) begin
      if (prim_start) begin
        adc_hold <= adc_word;
      end
      if (sample && slot == SLOT_SEC && int'(bitn) == HDR_W) begin
        hdr_addr <= full[ADDR_W-1:0];
      end
      if (sample && int'(bitn) == WORD_W) begin
        if (slot == SLOT_PRIM) dac_word <= full;
        if (slot == SLOT_SEC)  sec_word <= full;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      dout    <= 1'b0;
      rx      <= '0;
      rd_sel  <= 1'b0;
      dac_stb <= 1'b0;
      hdr_vld <= 1'b0;
      sec_vld <= 1'b0;
    end else begin
      dac_stb <= 1'b0;
      hdr_vld <= 1'b0;
      sec_vld <= 1'b0;
      if (launch) begin
        unique case (slot)
          SLOT_PRIM: dout <= adc_hold[tx_ix];
          SLOT_SEC:  dout <= (rd_sel && int'(bitn) > HDR_W) ? rd_data[rd_ix] : 1'b0;
          default:   dout <= 1'b0;
        endcase
      end
      if (sample && slot != SLOT_IDLE) begin
        rx <= full[WORD_W-2:0];
        if (slot == SLOT_SEC && int'(bitn) == 1)      rd_sel  <= din;
        if (slot == SLOT_SEC && int'(bitn) == HDR_W)  hdr_vld <= 1'b1;
        if (int'(bitn) == WORD_W) begin
          if (slot == SLOT_PRIM) dac_stb <= 1'b1;
          if (slot == SLOT_SEC)  sec_vld <= 1'b1;
        end
      end
    end
  end

  // R4: the DAC strobe lasts exactly one cycle
  a_r4_dac_stb_one: assert property (@(posedge clk) disable iff (rst)
    dac_stb |=> !dac_stb);

  // R5: a control word never completes together with a sample word
  a_r5_sec_not_prim: assert property (@(posedge clk) disable iff (rst)
    sec_vld |-> !dac_stb);

endmodule

// File: rtl/sport_regfile.sv
module sport_regfile #(
  parameter int NREG   = 8,
  parameter int DAT_W  = 8,
  parameter int ADDR_W = 7,
  parameter logic [DAT_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_vld,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              wr_vld,
  input  logic              wr_rw,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DAT_W-1:0]  wr_data,
  input  logic              sec_start,
  output logic [DAT_W-1:0]  rd_data,
  output logic              wr_stb,
  output logic              req_sw
);

  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DAT_W-1:0] mem [NREG];

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return int'(a) < NREG;
  endfunction

  assign req_sw = mem[0][0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        mem[i] <= RST_VAL;
      end
      rd_data <= '0;
      wr_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (hdr_vld) begin
        rd_data <= hit(hdr_addr) ? mem[hdr_addr[IDX_W-1:0]] : '0;
      end
      if (sec_start) begin
        mem[0][0] <= 1'b0;
      end
      if (wr_vld && !wr_rw && hit(wr_addr)) begin
        mem[wr_addr[IDX_W-1:0]] <= wr_data;
        wr_stb <= 1'b1;
      end
    end
  end

  // R7: a write strobe only follows a completed control word
  a_r7_wr_after_word: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(wr_vld));

endmodule

// File: rtl/codec_sport.sv
module codec_sport
  import sport_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int DIV     = 4,
  parameter int PERIOD  = 64,
  parameter int SEC_OFS = 32,
  parameter int NREG    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [WORD_W-1:0] adc_word,
  input  logic              req_pin,
  input  logic              din,
  output logic              sclk,
  output logic              fs_n,
  output logic              dout,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_stb,
  output logic              wr_stb
);

  localparam int DAT_W  = WORD_W / 2;
  localparam int ADDR_W = DAT_W - 1;
  localparam int BN_W   = $clog2(WORD_W + 1);

  logic              launch;
  logic              sample;
  logic              prim_start;
  logic              sec_start;
  slot_e             slot;
  logic [BN_W-1:0]   bitn;
  logic              req_sw;
  logic [DAT_W-1:0]  rd_data;
  logic              hdr_vld;
  logic [ADDR_W-1:0] hdr_addr;
  logic              sec_vld;
  logic [WORD_W-1:0] sec_word;

  sport_timebase #(
    .DIV(DIV), .WORD_W(WORD_W), .PERIOD(PERIOD), .SEC_OFS(SEC_OFS), .BN_W(BN_W)
  ) u_timebase (
    .clk(clk), .rst(rst), .run_en(run_en), .req_pin(req_pin), .req_sw(req_sw),
    .sclk(sclk), .fs_n(fs_n), .launch(launch), .sample(sample),
    .prim_start(prim_start), .sec_start(sec_start), .slot(slot), .bitn(bitn)
  );

  sport_shifter #(
    .WORD_W(WORD_W), .DAT_W(DAT_W), .ADDR_W(ADDR_W), .BN_W(BN_W)
  ) u_shifter (
    .clk(clk), .rst(rst), .run_en(run_en), .launch(launch), .sample(sample),
    .prim_start(prim_start), .slot(slot), .bitn(bitn), .adc_word(adc_word),
    .din(din), .rd_data(rd_data), .dout(dout), .dac_word(dac_word),
    .dac_stb(dac_stb), .hdr_vld(hdr_vld), .hdr_addr(hdr_addr),
    .sec_vld(sec_vld), .sec_word(sec_word)
  );

  sport_regfile #(
    .NREG(NREG), .DAT_W(DAT_W), .ADDR_W(ADDR_W)
  ) u_regfile (
    .clk(clk), .rst(rst), .hdr_vld(hdr_vld), .hdr_addr(hdr_addr),
    .wr_vld(sec_vld), .wr_rw(sec_word[WORD_W-1]),
    .wr_addr(sec_word[WORD_W-2:DAT_W]), .wr_data(sec_word[DAT_W-1:0]),
    .sec_start(sec_start), .rd_data(rd_data), .wr_stb(wr_stb), .req_sw(req_sw)
  );

  // R5: sample and register strobes never coincide
  a_r5_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(dac_stb && wr_stb));

endmodule

// File: tb/codec_sport_tb.sv
module codec_sport_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b1;
  logic [15:0] adc_word = '0;
  logic        req_pin = 1'b0;
  logic        din = 1'b0;
  logic        sclk, fs_n, dout, dac_stb, wr_stb;
  logic [15:0] dac_word;

  int errs = 0;
  int checks = 0;

  // host model state
  logic [15:0] prim_tx = '0, sec_tx = '0, prim_rx = '0, sec_rx = '0, tx = '0, rx = '0;
  int  prim_n = 0, sec_n = 0, prim_starts = 0, dac_n = 0, wr_n = 0;
  int  gap = 0, cnt = 0;
  bit  armed = 0, first = 1, is_sec = 0, sclk_prev = 0;
  logic [15:0] dac_last = '0;

  always #10 clk = ~clk;

  codec_sport u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .adc_word(adc_word), .req_pin(req_pin),
    .din(din), .sclk(sclk), .fs_n(fs_n), .dout(dout), .dac_word(dac_word),
    .dac_stb(dac_stb), .wr_stb(wr_stb)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Host side of the link: reacts to shift-clock rising edges.
  always @(negedge clk) begin
    if (rst || !run_en) begin
      armed = 0;
      first = 1;
      gap   = 0;
    end else if (sclk && !sclk_prev) begin
      if (!fs_n) begin
        if (!first && gap == 32) begin
          is_sec = 1;
        end else begin
          is_sec = 0;
          if (!first) chk(gap == 64, "R3 primary spacing", gap, 64);
          gap = 0;
          prim_starts++;
        end
        first = 0;
        armed = 1;
        cnt   = 0;
        tx    = is_sec ? sec_tx : prim_tx;
      end else if (armed) begin
        rx  = {rx[14:0], dout};
        cnt = cnt + 1;
        din = tx[16-cnt];
        if (cnt == 16) begin
          armed = 0;
          if (is_sec) begin sec_rx = rx; sec_n++; end
          else begin prim_rx = rx; prim_n++; end
        end
      end
      gap = gap + 1;
    end
    sclk_prev = sclk;
    if (dac_stb) begin dac_n++; dac_last = dac_word; end
    if (wr_stb) wr_n++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_prims(input int n);
    int tgt = prim_n + n;
    while (prim_n < tgt) @(negedge clk);
    wait_clk(8);
  endtask

  task automatic sec_xfer(input logic [15:0] w, output logic [15:0] r);
    int tgt = sec_n + 1;
    sec_tx = w;
    @(negedge clk) req_pin = 1'b1;
    @(negedge clk) req_pin = 1'b0;
    while (sec_n < tgt) @(negedge clk);
    wait_clk(8);
    r = sec_rx;
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    wait_clk(3);
    chk(!sclk && fs_n && !dout && !dac_stb && !wr_stb, "R12 idle in reset",
        {sclk, fs_n, dout, dac_stb, wr_stb}, 5'b01000);
    @(negedge clk) rst = 1'b0;
    prim_n = 0; sec_n = 0; dac_n = 0; wr_n = 0;
  endtask

  task automatic t_sclk_shape();
    int per = 0, hi = 0;
    while (!(sclk && !sclk_prev)) @(negedge clk);
    @(negedge clk);
    per = 1; hi = 1;
    while (!(sclk && !sclk_prev)) begin
      if (sclk) hi++;
      per++;
      @(negedge clk);
    end
    chk(per == 4, "R1 sclk period", per, 4);
    chk(hi == 2, "R1 sclk high time", hi, 2);
  endtask

  task automatic t_prim(input logic [15:0] a, input logic [15:0] d);
    adc_word = a;
    prim_tx  = d;
    wait_prims(2);
    chk(prim_rx == a, "R3 adc word on dout", prim_rx, a);
    chk(dac_last == d, "R4 dac word", dac_last, d);
    chk(dac_n == prim_n, "R4 one strobe per frame", dac_n, prim_n);
  endtask

  task automatic t_adc_latch();
    int s;
    adc_word = 16'h1357;
    wait_prims(1);
    s = prim_starts;
    while (prim_starts == s) @(negedge clk);
    adc_word = 16'hECA8;
    wait_prims(1);
    chk(prim_rx == 16'h1357, "R3 latched at fs edge", prim_rx, 16'h1357);
    wait_prims(1);
    chk(prim_rx == 16'hECA8, "R3 new value next frame", prim_rx, 16'hECA8);
  endtask

  task automatic t_no_sec();
    int s;
    wait_prims(1);
    s = sec_n;
    wait_prims(3);
    chk(sec_n == s, "R5 no request no secondary", sec_n, s);
  endtask

  task automatic t_write_read();
    logic [15:0] r;
    int w0 = wr_n;
    sec_xfer({1'b0, 7'd3, 8'h5A}, r);
    chk(r == 16'h0000, "R8 write window dout zero", r, 0);
    chk(wr_n == w0 + 1, "R7 write strobe", wr_n, w0 + 1);
    sec_xfer({1'b0, 7'd5, 8'hC3}, r);
    sec_xfer({1'b1, 7'd3, 8'h00}, r);
    chk(r == 16'h005A, "R8 read reg3", r, 16'h005A);
    sec_xfer({1'b1, 7'd5, 8'hFF}, r);
    chk(r == 16'h00C3, "R7 read reg5", r, 16'h00C3);
  endtask

  task automatic t_out_of_range();
    logic [15:0] r;
    int w0 = wr_n;
    sec_xfer({1'b0, 7'h7F, 8'hEE}, r);
    chk(wr_n == w0, "R9 no strobe out of range", wr_n, w0);
    sec_xfer({1'b1, 7'h7F, 8'h00}, r);
    chk(r == 16'h0000, "R9 read high addr", r, 0);
    sec_xfer({1'b1, 7'd8, 8'h00}, r);
    chk(r == 16'h0000, "R9 read addr NREG", r, 0);
    sec_xfer({1'b1, 7'd3, 8'h00}, r);
    chk(r == 16'h005A, "R9 reg3 untouched", r, 16'h005A);
  endtask

  task automatic t_sw_req();
    logic [15:0] r;
    int s;
    sec_xfer({1'b0, 7'd0, 8'h01}, r);
    sec_tx = {1'b1, 7'd0, 8'h00};
    s = sec_n + 1;
    while (sec_n < s) @(negedge clk);
    wait_clk(8);
    chk(sec_rx == 16'h0000, "R10 sw bit cleared at start", sec_rx, 0);
    wait_prims(1);
    s = sec_n;
    wait_prims(3);
    chk(sec_n == s, "R10 single sw secondary", sec_n, s);
  endtask

  task automatic t_pin_held();
    int s;
    sec_tx = {1'b1, 7'd3, 8'h00};
    req_pin = 1'b1;
    wait_prims(1);
    s = sec_n;
    wait_prims(3);
    chk(sec_n == s + 3, "R6 held pin every period", sec_n, s + 3);
    chk(sec_rx == 16'h005A, "R6 read while held", sec_rx, 16'h005A);
    req_pin = 1'b0;
    wait_prims(2);
    s = sec_n;
    wait_prims(3);
    chk(sec_n == s, "R6 released pin stops", sec_n, s);
  endtask

  task automatic t_power_down();
    logic [15:0] r;
    int s, d0, bad = 0;
    wait_prims(1);
    s = prim_starts;
    while (prim_starts == s) @(negedge clk);
    wait_clk(20);
    d0 = dac_n;
    @(negedge clk) run_en = 1'b0;
    @(negedge clk);
    repeat (100) begin
      @(negedge clk);
      if (sclk || !fs_n) bad++;
    end
    chk(bad == 0, "R11 link idle while down", bad, 0);
    chk(dac_n == d0, "R11 no strobe for cut frame", dac_n, d0);
    run_en = 1'b1;
    @(negedge clk);
    chk(fs_n == 1'b0, "R11 frame on first edge", fs_n, 0);
    sec_xfer({1'b1, 7'd3, 8'h00}, r);
    chk(r == 16'h005A, "R11 registers kept", r, 16'h005A);
  endtask

  task automatic t_reset_clears();
    logic [15:0] r;
    t_reset();
    sec_xfer({1'b1, 7'd3, 8'h00}, r);
    chk(r == 16'h0000, "R12 reg3 cleared", r, 0);
    sec_xfer({1'b1, 7'd5, 8'h00}, r);
    chk(r == 16'h0000, "R12 reg5 cleared", r, 0);
  endtask

  initial begin
    t_reset();
    t_sclk_shape();
    t_prim(16'hA5C3, 16'h1234);
    t_prim(16'hFFFF, 16'h0000);
    t_prim(16'h0000, 16'hFFFF);
    t_prim(16'h8001, 16'h7FFE);
    t_adc_latch();
    t_no_sec();
    t_write_read();
    t_out_of_range();
    t_sw_req();
    t_pin_held();
    t_power_down();
    t_reset_clears();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule